// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Target

This block is the card-side bus decode of a 16-bit PC Card-style target. From the register-select line, the two chip enables, the address (bit 0 included) and the strobes of the memory cycle (OE#/WE#) and the I/O cycle (IORD#/IOWR#), it works out which space a host cycle addresses and how wide the cycle is. There are three cases: attribute space, task-file registers reached through I/O cycles, and the same task-file registers reached through memory cycles.

For reads, it places each byte on the low lane (D0-D7) or the high lane (D8-D15) and raises a separate output enable for each lane. It also drives the I/O-acknowledge (INPACK#) and 16-bit-port (IOIS16#) indications. A 256-entry attribute store and an 8-byte task-file array stand in for the real targets.

Reads are combinational from the pins. Writes pass through the card clock domain: the strobe is synchronised, and the write is committed on the strobe's rising edge using the address and data held while the strobe was low. All pins are plain levels; there is no valid/ready flow at this edge, because the host cycle timing sets the pace.

Top module: `pcc_lane_target`

## Requirements
- R1: With ce1_n and ce2_n both high, neither lane enable is asserted, inpack_n and iois16_n stay high, and a write cycle changes no stored byte.
- R2: With ce1_n low, ce2_n high and addr[0]=0, only lo_oe is asserted, and the byte at the even address appears on rdata[7:0].
- R3: With ce1_n low, ce2_n high and addr[0]=1, only lo_oe is asserted. A task-file read returns the odd byte on rdata[7:0]; an attribute read returns 0x00 there.
- R4: With ce1_n and ce2_n both low, both lane enables are asserted and addr[0] is ignored. The even byte goes on rdata[7:0] and the odd byte on rdata[15:8].
- R5: With ce1_n high and ce2_n low, only hi_oe is asserted, and the odd byte appears on rdata[15:8].
- R6: The space is chosen as follows. reg_n=0 with oe_n/we_n addresses attribute space. reg_n=0 with iord_n/iowr_n addresses the task file. reg_n=1 with oe_n/we_n addresses the same task file. An iord_n/iowr_n cycle with reg_n=1 drives no lane and writes nothing.
- R7: Attribute entry k (0..255) sits at byte address 2k, selected by addr[8:1]. Entries 0..127 are a read-only pattern equal to k XOR 0xC3, and writes to them are dropped. Entries 128..255 reset to 0x00 and are writable.
- R8: Odd attribute byte addresses read as 0x00, and writes to them are dropped.
- R9: The task file holds 8 writable bytes selected by addr[2:0]. All reset to 0x00, and higher address bits are ignored.
- R10: inpack_n is low exactly while reg_n=0, iord_n=0 and at least one chip enable is low. It goes high as soon as iord_n rises.
- R11: iois16_n is low combinationally whenever reg_n=0, a chip enable is low and addr[2:1]=0 (the 16-bit data register pair).
- R12: A write commits on the rising edge of we_n/iowr_n using the address, data and enables sampled while the strobe was low. It is readable 4 clock cycles later, and changes made to addr/wdata after the rising edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_n | input | 1 | Register select, active low |
| ce1_n | input | 1 | Low-lane chip enable, active low |
| ce2_n | input | 1 | High-lane chip enable, active low |
| oe_n | input | 1 | Memory read strobe |
| we_n | input | 1 | Memory write strobe |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| addr | input | 9 | Byte address, bit 0 is A0 |
| wdata | input | 16 | Host write data, both lanes |
| rdata | output | 16 | Read data, 0 on any undriven lane |
| lo_oe | output | 1 | Drive enable for rdata[7:0] |
| hi_oe | output | 1 | Drive enable for rdata[15:8] |
| inpack_n | output | 1 | I/O read acknowledge, active low |
| iois16_n | output | 1 | 16-bit port indication, active low |

## Verification
The embedded assertions check, on every cycle:
- standby silences every output;
- an odd-byte cycle never enables the low lane;
- the acknowledge releases once the I/O read strobe is high;
- the 16-bit indication needs register select;
- the write-commit pulse lasts one cycle;
- a task-file commit lands in the array;
- the read-only pattern survives a write aimed at it.

Only the bench's sweeps can show that each chip-enable combination carries the correct byte on the correct lane, in all three spaces. The same holds for the data-register decode over all eight addresses, for dropped writes to odd and pattern addresses, and for write data being sampled before the strobe rises rather than after.

// File: rtl/pcc_steer_pkg.sv
package pcc_steer_pkg;

  typedef enum logic [1:0] {
    SPC_NONE = 2'd0,
    SPC_ATTR = 2'd1,
    SPC_TASK = 2'd2
  } space_e;

  // Fixed read-only pattern of the protected attribute entries
  function automatic logic [7:0] cis_fill(input int unsigned idx);
    logic [31:0] v;
    v = idx;
    return v[7:0] ^ 8'hC3;
  endfunction

endpackage

// File: rtl/pcc_space_decode.sv
module pcc_space_decode
  import pcc_steer_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int TF_AW  = 3
) (
  input  logic              reg_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic [ADDR_W-1:0] addr,
  output space_e            rd_space,
  output space_e            wr_space,
  output logic              lo_en,
  output logic              hi_en,
  output logic              inpack_n,
  output logic              iois16_n,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [ADDR_W-1:0] hi_addr
);

  logic sel;
  logic io_rd, attr_rd, mem_rd;
  logic io_wr, attr_wr, mem_wr;

  always_comb begin
    sel     = !(ce1_n && ce2_n);
    io_rd   = !reg_n && !iord_n;
    attr_rd = !reg_n && iord_n && !oe_n;
    mem_rd  = reg_n && !oe_n;
    io_wr   = !reg_n && !iowr_n;
    attr_wr = !reg_n && iowr_n && !we_n;
    mem_wr  = reg_n && !we_n;

    if (!sel)                  rd_space = SPC_NONE;
    else if (io_rd || mem_rd)  rd_space = SPC_TASK;
    else if (attr_rd)          rd_space = SPC_ATTR;
    else                       rd_space = SPC_NONE;

    if (!sel)                  wr_space = SPC_NONE;
    else if (io_wr || mem_wr)  wr_space = SPC_TASK;
    else if (attr_wr)          wr_space = SPC_ATTR;
    else                       wr_space = SPC_NONE;

    lo_en    = (rd_space != SPC_NONE) && !ce1_n;
    hi_en    = (rd_space != SPC_NONE) && !ce2_n;
    inpack_n = !(sel && io_rd);
    iois16_n = !(sel && !reg_n && (addr[TF_AW-1:1] == '0));

    // byte-enable single lane uses A0 directly; word uses the even byte
    lo_addr  = ce2_n ? addr : {addr[ADDR_W-1:1], 1'b0};
    hi_addr  = {addr[ADDR_W-1:1], 1'b1};
  end

endmodule

// File: rtl/pcc_write_capture.sv
module pcc_write_capture
  import pcc_steer_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  space_e                 wr_space_in,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [15:0]            wdata,
  input  logic                   ce1_n,
  input  logic                   ce2_n,
  output logic                   wr_pulse,
  output space_e                 wr_space,
  output logic [1:0]             wr_en,
  output logic [1:0][ADDR_W-1:0] wr_addr,
  output logic [1:0][7:0]        wr_data
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0]  act_q;
  logic              act;
  logic [ADDR_W-1:0] hold_addr;
  logic [15:0]       hold_data;
  logic              hold_lo, hold_hi, hold_ce2_n;
  space_e            hold_sp;

  assign act = (wr_space_in != SPC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= '0;
      hold_addr  <= '0;
      hold_data  <= '0;
      hold_lo    <= 1'b0;
      hold_hi    <= 1'b0;
      hold_ce2_n <= 1'b1;
      hold_sp    <= SPC_NONE;
    end else begin
      act_q <= {act_q[CHAIN-2:0], act};
      if (act) begin
        hold_addr  <= addr;
        hold_data  <= wdata;
        hold_lo    <= !ce1_n;
        hold_hi    <= !ce2_n;
        hold_ce2_n <= ce2_n;
        hold_sp    <= wr_space_in;
      end
    end
  end

  // strobe rising edge == active level falling in the synchronised chain
  assign wr_pulse   = act_q[CHAIN-1] && !act_q[CHAIN-2];
  assign wr_space   = hold_sp;
  assign wr_en      = {hold_hi, hold_lo};
  assign wr_addr[0] = hold_ce2_n ? hold_addr : {hold_addr[ADDR_W-1:1], 1'b0};
  assign wr_addr[1] = {hold_addr[ADDR_W-1:1], 1'b1};
  assign wr_data[0] = hold_data[7:0];
  assign wr_data[1] = hold_data[15:8];

  // R12
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R12
  commit_has_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (wr_space != SPC_NONE));

endmodule

// File: rtl/pcc_attr_store.sv
module pcc_attr_store
  import pcc_steer_pkg::*;
#(
  parameter int ATTR_AW   = 8,
  parameter int CIS_BYTES = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_pulse,
  input  space_e                  wr_space,
  input  logic [1:0]              wr_en,
  input  logic [1:0][ATTR_AW:0]   wr_addr,
  input  logic [1:0][7:0]         wr_data,
  input  logic [1:0][ATTR_AW:0]   rd_addr,
  output logic [1:0][7:0]         rd_data
);

  localparam int ENTRIES = 1 << ATTR_AW;

  logic [7:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        mem[i] <= (i < CIS_BYTES) ? cis_fill(i) : 8'h00;
    end else if (wr_pulse && wr_space == SPC_ATTR) begin
      for (int ln = 0; ln < 2; ln++) begin
        if (wr_en[ln] && !wr_addr[ln][0] &&
            int'(wr_addr[ln][ATTR_AW:1]) >= CIS_BYTES)
          mem[wr_addr[ln][ATTR_AW:1]] <= wr_data[ln];
      end
    end
  end

  for (genvar ln = 0; ln < 2; ln++) begin : g_rd
    assign rd_data[ln] = rd_addr[ln][0] ? 8'h00 : mem[rd_addr[ln][ATTR_AW:1]];
  end

  // R7
  cis_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && wr_space == SPC_ATTR && wr_en[0] &&
     wr_addr[0][ATTR_AW:1] == '0) |=> $stable(mem[0]));

endmodule

// File: rtl/pcc_task_store.sv
module pcc_task_store
  import pcc_steer_pkg::*;
#(
  parameter int TF_AW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_pulse,
  input  space_e                wr_space,
  input  logic [1:0]            wr_en,
  input  logic [1:0][TF_AW-1:0] wr_addr,
  input  logic [1:0][7:0]       wr_data,
  input  logic [1:0][TF_AW-1:0] rd_addr,
  output logic [1:0][7:0]       rd_data
);

  localparam int REGS = 1 << TF_AW;

  logic [7:0] mem [REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) mem[i] <= 8'h00;
    end else if (wr_pulse && wr_space == SPC_TASK) begin
      for (int ln = 0; ln < 2; ln++)
        if (wr_en[ln]) mem[wr_addr[ln]] <= wr_data[ln];
    end
  end

  for (genvar ln = 0; ln < 2; ln++) begin : g_rd
    assign rd_data[ln] = mem[rd_addr[ln]];
  end

  // R9
  tf_store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && wr_space == SPC_TASK && wr_en[0]) |=>
      (mem[$past(wr_addr[0])] == $past(wr_data[0])));

endmodule

// File: rtl/pcc_lane_target.sv
module pcc_lane_target
  import pcc_steer_pkg::*;
#(
  parameter int ATTR_AW   = 8,
  parameter int TF_AW     = 3,
  parameter int CIS_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_n,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             iord_n,
  input  logic             iowr_n,
  input  logic [ATTR_AW:0] addr,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  output logic             lo_oe,
  output logic             hi_oe,
  output logic             inpack_n,
  output logic             iois16_n
);

  localparam int ADDR_W = ATTR_AW + 1;

  space_e                 rd_space, wr_space_raw, wr_space;
  logic                   lo_en, hi_en, wr_pulse;
  logic [ADDR_W-1:0]      lo_addr, hi_addr;
  logic [1:0]             wr_en;
  logic [1:0][ADDR_W-1:0] wr_addr;
  logic [1:0][7:0]        wr_data;
  logic [1:0][ADDR_W-1:0] attr_rd_addr;
  logic [1:0][TF_AW-1:0]  tf_rd_addr, tf_wr_addr;
  logic [1:0][7:0]        attr_rd, tf_rd;

  pcc_space_decode #(.ADDR_W(ADDR_W), .TF_AW(TF_AW)) u_dec (
    .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .addr(addr),
    .rd_space(rd_space), .wr_space(wr_space_raw),
    .lo_en(lo_en), .hi_en(hi_en), .inpack_n(inpack_n), .iois16_n(iois16_n),
    .lo_addr(lo_addr), .hi_addr(hi_addr)
  );

  pcc_write_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_space_in(wr_space_raw), .addr(addr),
    .wdata(wdata), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .wr_pulse(wr_pulse), .wr_space(wr_space), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign attr_rd_addr = {hi_addr, lo_addr};
  assign tf_rd_addr   = {hi_addr[TF_AW-1:0], lo_addr[TF_AW-1:0]};
  assign tf_wr_addr   = {wr_addr[1][TF_AW-1:0], wr_addr[0][TF_AW-1:0]};

  pcc_attr_store #(.ATTR_AW(ATTR_AW), .CIS_BYTES(CIS_BYTES)) u_attr (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_space(wr_space),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(attr_rd_addr), .rd_data(attr_rd)
  );

  pcc_task_store #(.TF_AW(TF_AW)) u_tf (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_space(wr_space),
    .wr_en(wr_en), .wr_addr(tf_wr_addr), .wr_data(wr_data),
    .rd_addr(tf_rd_addr), .rd_data(tf_rd)
  );

  always_comb begin
    rdata[7:0]  = !lo_en ? 8'h00 : (rd_space == SPC_ATTR) ? attr_rd[0] : tf_rd[0];
    rdata[15:8] = !hi_en ? 8'h00 : (rd_space == SPC_ATTR) ? attr_rd[1] : tf_rd[1];
    lo_oe = lo_en;
    hi_oe = hi_en;
  end

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |-> (!lo_oe && !hi_oe && inpack_n && iois16_n));

  // R5
  odd_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && !ce2_n) |-> !lo_oe);

  // R10
  inpack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iord_n |-> inpack_n);

  // R11
  iois16_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iois16_n |-> !reg_n);

endmodule

// File: tb/pcc_lane_target_test.sv
module pcc_lane_target_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1;
  logic oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic lo_oe, hi_oe, inpack_n, iois16_n;

  int nchk = 0;
  int nerr = 0;

  logic [7:0] tf_m [8];
  logic [7:0] at_m [256];

  always #4 clk = ~clk;

  pcc_lane_target uut (
    .clk(clk), .rst_n(rst_n), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .lo_oe(lo_oe), .hi_oe(hi_oe),
    .inpack_n(inpack_n), .iois16_n(iois16_n)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit attr, input logic [8:0] a);
    if (attr) return a[0] ? 8'h00 : at_m[a[8:1]];
    return tf_m[a[2:0]];
  endfunction

  task automatic model_put(input bit attr, input logic [8:0] a, input logic [7:0] v);
    if (attr) begin
      if (!a[0] && a[8:1] >= 9'd128) at_m[a[8:1]] = v;
    end else begin
      tf_m[a[2:0]] = v;
    end
  endtask

  task automatic release_pins();
    reg_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
    oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
  endtask

  // sp: 0 attribute, 1 I/O task file, 2 memory task file, 3 I/O strobe with reg_n high
  task automatic wr(input int sp, input logic c1, input logic c2,
                    input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_n = (sp >= 2); ce1_n = c1; ce2_n = c2; addr = a; wdata = d;
    if (sp == 0 || sp == 2) we_n = 1'b0; else iowr_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; iowr_n = 1'b1;
    addr = ~a; wdata = ~d;   // R12: post-edge changes must not matter
    @(negedge clk);
    release_pins();
    repeat (3) @(negedge clk);
    if (sp < 3 && !(c1 && c2)) begin
      if (!c1) model_put(sp == 0, c2 ? a : {a[8:1], 1'b0}, d[7:0]);
      if (!c2) model_put(sp == 0, {a[8:1], 1'b1}, d[15:8]);
    end
  endtask

  task automatic rd(input int sp, input logic c1, input logic c2,
                    input logic [8:0] a, input string req);
    bit act, elo, ehi;
    @(negedge clk);
    reg_n = (sp >= 2); ce1_n = c1; ce2_n = c2; addr = a;
    if (sp == 0 || sp == 2) oe_n = 1'b0; else iord_n = 1'b0;
    #2;
    act = (sp < 3) && !(c1 && c2);
    elo = act && !c1;
    ehi = act && !c2;
    check(req, "lo_oe", {15'd0, lo_oe}, {15'd0, elo});
    check(req, "hi_oe", {15'd0, hi_oe}, {15'd0, ehi});
    if (elo) check(req, "low lane", {8'd0, rdata[7:0]},
                   {8'd0, exp_byte(sp == 0, c2 ? a : {a[8:1], 1'b0})});
    if (ehi) check(req, "high lane", {8'd0, rdata[15:8]},
                   {8'd0, exp_byte(sp == 0, {a[8:1], 1'b1})});
    check("R10", "inpack_n", {15'd0, inpack_n},
          {15'd0, !(sp == 1 && !(c1 && c2))});
    @(negedge clk);
    release_pins();
    #1;
    if (sp == 1) check("R10", "inpack_n after iord rise", {15'd0, inpack_n}, 16'd1);
  endtask

  function automatic string mode_tag(input logic c1, input logic c2, input logic a0);
    if (c1 && c2) return "R1";
    if (!c1 && c2) return a0 ? "R3" : "R2";
    if (!c1 && !c2) return "R4";
    return "R5";
  endfunction

  task automatic tf_sweep();
    for (int sp = 1; sp <= 2; sp++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 8; a++) begin
          logic c1, c2;
          c1 = (m == 2 || m == 3);
          c2 = (m == 0 || m == 3);
          rd(sp, c1, c2, 9'(a) | 9'h1F0, mode_tag(c1, c2, a[0]));  // R9: high bits ignored
        end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) tf_m[i] = 8'h00;
    for (int i = 0; i < 256; i++) at_m[i] = (i < 128) ? (8'(i) ^ 8'hC3) : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset and standby state
    check("R1", "lo_oe idle", {15'd0, lo_oe}, 16'd0);
    check("R1", "hi_oe idle", {15'd0, hi_oe}, 16'd0);
    check("R1", "inpack idle", {15'd0, inpack_n}, 16'd1);
    check("R1", "iois16 idle", {15'd0, iois16_n}, 16'd1);

    // R7: full attribute sweep after reset (pattern and zeroed entries)
    for (int k = 0; k < 256; k++) rd(0, 1'b0, 1'b1, 9'(2 * k), "R7");
    // R8 / R3: odd attribute addresses read zero
    for (int k = 0; k < 256; k += 17) rd(0, 1'b0, 1'b1, 9'(2 * k + 1), "R8");
    // R9: task file all zero after reset
    tf_sweep();

    // task-file writes in several lane modes and both mappings (R6, R9, R12)
    for (int r = 0; r < 8; r++) wr(1, 1'b0, 1'b1, 9'(r), 16'(r * 37 + 5));
    tf_sweep();
    wr(2, 1'b0, 1'b0, 9'd3, 16'hBEEF);   // R4: word, A0 ignored
    wr(2, 1'b1, 1'b0, 9'd4, 16'h7700);   // R5: odd-byte write to byte 5
    wr(1, 1'b0, 1'b1, 9'd7, 16'h00A9);   // R3: odd byte via low lane
    tf_sweep();

    // R1: standby write ignored; R6: I/O strobe with reg_n high ignored
    wr(1, 1'b1, 1'b1, 9'd0, 16'hFFFF);
    wr(3, 1'b0, 1'b0, 9'd0, 16'h5555);
    rd(1, 1'b0, 1'b0, 9'd0, "R1");
    rd(3, 1'b0, 1'b0, 9'd0, "R6");
    rd(1, 1'b0, 1'b0, 9'd0, "R6");

    // attribute writes (R7, R8)
    wr(0, 1'b0, 1'b1, 9'd10, 16'h00EE);      // pattern entry, dropped
    wr(0, 1'b0, 1'b1, 9'd0,  16'h0011);      // pattern entry 0, dropped
    wr(0, 1'b0, 1'b1, 9'd400, 16'h00AB);     // entry 200
    wr(0, 1'b0, 1'b1, 9'd401, 16'h00CD);     // odd, dropped
    wr(0, 1'b0, 1'b0, 9'd402, 16'h1234);     // word: entry 201 = 34
    wr(0, 1'b1, 1'b0, 9'd404, 16'h9900);     // odd-byte lane only, dropped
    wr(0, 1'b0, 1'b1, 9'd510, 16'h0042);     // last entry
    for (int k = 0; k < 256; k++) rd(0, 1'b0, 1'b0, 9'(2 * k), "R7");
    rd(0, 1'b1, 1'b0, 9'd401, "R8");
    rd(0, 1'b0, 1'b1, 9'd401, "R8");

    // R11: data-register decode over all task-file addresses
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      reg_n = 1'b0; ce1_n = 1'b0; ce2_n = 1'b1; addr = 9'(a);
      #2;
      check("R11", "iois16_n", {15'd0, iois16_n}, {15'd0, !(a < 2)});
      reg_n = 1'b1;
      #1;
      check("R11", "iois16_n reg high", {15'd0, iois16_n}, 16'd1);
      release_pins();
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule